// File: doc/BRIEF.md
# Register-Window Wishbone Master Bridge

This block sits as a slave on a 16-bit processor I/O bus and lets software run single 32-bit Wishbone master transfers through a window of eight 16-bit words. Software places a 32-bit target address and 32-bit data into the window as pairs of 16-bit halves. It also programs four byte-lane selects and a cycle style, either classic or pipelined, in a control word. The transfer starts as a side effect of writing the upper half of an address pair. The pair that was written decides the direction: the read pair issues a read and the write pair issues a write.

While a transfer is outstanding, bit 15 of the control word reads as 1, and software polls it until it returns to 0. When a read is acknowledged, the returned bus word lands in the data pair in the same clock in which the pending flag clears. For a byte access, software enables the single select bit named by target address bits 1:0 and uses the matching byte of the data pair.

Top module: `wbbr_top`

## Requirements
- R1: After a synchronous active-low reset, `wb_cyc_o`, `wb_stb_o` and `wb_we_o` are 0, `wb_sel_o`, `wb_adr_o` and `wb_dat_o` are zero, and the control word (word index 7) reads as 0.
- R2: Address and data halves take byte-lane writes: `bus_wren[0]` updates bits 7:0 and `bus_wren[1]` updates bits 15:8 of the addressed half, and a lane whose strobe is low keeps its value. The halves are at these word indices: 0 and 2 for address bits 15:0, 1 and 3 for address bits 31:16, 4 for data bits 15:0, and 5 for data bits 31:16. Data halves read back at indices 4 and 5.
- R3: A write with any strobe to word 1 starts a read cycle, and a write to word 3 starts a write cycle. On the next clock, `wb_cyc_o` and `wb_stb_o` are 1 and `wb_adr_o` shows the full 32-bit address.
- R4: A write to word 0 or word 1 sets `wb_we_o` to 0. A write to word 2 or word 3 sets it to 1.
- R5: A low-lane write to the control word (index 7) loads bits 3:0 into `wb_sel_o` (bit n enables data byte n) and bit 4 into the cycle style (1 = pipelined). A write with only the high lane strobed changes nothing. Control bits 3:0 and 4 read back in place.
- R6: In a classic cycle, `wb_stb_o` and `wb_cyc_o` stay 1 until the clock in which `wb_ack_i` is sampled high, and `wb_stb_o` is never 1 without `wb_cyc_o`.
- R7: In a pipelined cycle, `wb_stb_o` is 1 for exactly one clock, and `wb_cyc_o` stays 1 until acknowledge.
- R8: Control bit 15 reads 1 while a cycle is outstanding. It clears, together with `wb_cyc_o` and `wb_stb_o`, on the clock edge that samples `wb_ack_i` high.
- R9: An acknowledged read copies `wb_dat_i` into the data pair on the same edge that ends the cycle. An acknowledged write leaves the data pair unchanged.
- R10: While a cycle is outstanding, every register write is ignored, including a new trigger. Address, data, direction, selects and style stay as launched.
- R11: `bus_rdata` is registered, with one clock of read latency. Word indices 0, 1, 2, 3 and 6 read as zero, and `bus_rdata` is zero in any clock following one without `bus_rden`.
- R12: `wb_ack_i` sampled while no cycle is outstanding has no effect on the data pair or on the bus signals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_word | input | 3 | Word index inside the window (byte offset divided by 2) |
| bus_rden | input | 1 | Read enable |
| bus_wren | input | 2 | Per-lane write strobes (bit 0 = bits 7:0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| wb_adr_o | output | 32 | Wishbone address |
| wb_dat_o | output | 32 | Wishbone write data (data pair contents) |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_sel_o | output | 4 | Wishbone byte selects |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
The data pair has two writers that can meet in one clock: the acknowledge capture of a read, and a software write to a data half. The bench provokes this by driving `wb_ack_i` and a full-word write to word 4 in the same cycle of an outstanding read. It then requires the data pair to hold the acknowledged bus word, with the cycle closed on that edge. The same collision is exercised for a trigger that lands while a cycle is still open, which must leave address and direction as launched.

// File: rtl/wbbr_pkg.sv
// Package: shared window layout for the register-window Wishbone bridge.
// Assumes a 16-bit host bus and eight word slots in the window.
package wbbr_pkg;

    // Word slots of the window; the read/write split of the address pairs
    // is decoded by the trigger logic, so these indices are behavioural.
    typedef enum logic [2:0] {
        W_RD_ADR_LO = 3'd0,
        W_RD_ADR_HI = 3'd1,
        W_WR_ADR_LO = 3'd2,
        W_WR_ADR_HI = 3'd3,
        W_DAT_LO    = 3'd4,
        W_DAT_HI    = 3'd5,
        W_RSVD      = 3'd6,
        W_CTRL      = 3'd7
    } win_word_e;

    localparam int CTRL_PIPE_BIT = 4;
    localparam int CTRL_PEND_BIT = 15;

endpackage

// File: rtl/wbbr_cycle.sv
// Module: Wishbone cycle sequencer.
// Raises CYC and STB one clock after a start pulse. In classic style STB is
// held until ACK. In pipelined style STB lasts one clock. CYC drops on the
// ACK edge. Assumes the style input is frozen while a cycle is open.
module wbbr_cycle (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pipe,
    input  logic ack,
    output logic cyc,
    output logic stb
);

    // Open, hold and close the bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= 1'b0;
            stb <= 1'b0;
        end else if (cyc) begin
            if (ack) begin
                cyc <= 1'b0;
                stb <= 1'b0;
            end else if (pipe) begin
                stb <= 1'b0;
            end
        end else if (start) begin
            cyc <= 1'b1;
            stb <= 1'b1;
        end
    end

    AST_START_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        start && !cyc |=> cyc && stb);                          // R3
    AST_STB_WITHIN_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> cyc);                                           // R6
    AST_CLASSIC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cyc && stb && !ack && !pipe |=> cyc && stb);            // R6
    AST_PIPE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb && pipe |=> !stb);                                  // R7
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        cyc && ack |=> !cyc && !stb);                           // R8
    AST_IDLE_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc && !start |=> !cyc);                               // R12

endmodule

// File: rtl/wbbr_regfile.sv
// Module: register window of the bridge.
// Holds the address pair, data pair, direction, byte selects and cycle style,
// with byte-lane writes and one-clock registered reads. Generates the start
// pulse when an upper address half is written. Captures bus read data on ACK.
// Assumes WB_W == 2*BUS_W and that 'pending' equals the open-cycle flag.
module wbbr_regfile
    import wbbr_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int WB_W   = 32,
    parameter int WIDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDX_W-1:0]    bus_word,
    input  logic                 bus_rden,
    input  logic [BUS_W/8-1:0]   bus_wren,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic                 pending,
    input  logic                 wb_ack,
    input  logic [WB_W-1:0]      wb_dat_i,
    output logic [WB_W-1:0]      adr_o,
    output logic [WB_W-1:0]      dat_o,
    output logic [WB_W/8-1:0]    sel_o,
    output logic                 we_o,
    output logic                 pipe_o,
    output logic                 start
);

    localparam int LANES = BUS_W / 8;
    localparam int SEL_W = WB_W / 8;

    win_word_e          widx;
    logic               wr_open;
    logic               capture;
    logic               hi_adr;
    logic               we_q;
    logic               pipe_q;
    logic [SEL_W-1:0]   sel_q;
    logic [BUS_W-1:0]   ctrl_word;

    assign widx    = win_word_e'(bus_word);
    assign wr_open = (|bus_wren) && !pending;
    assign hi_adr  = (widx == W_RD_ADR_HI) || (widx == W_WR_ADR_HI);
    assign start   = wr_open && hi_adr;
    assign capture = pending && wb_ack && !we_q;

    // Per-lane storage of address and data bytes.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] a_lo, a_hi, d_lo, d_hi;
        logic       lane_wr;
        assign lane_wr = bus_wren[b] && !pending;

        // Byte-lane update of the address and data halves, or capture on ACK.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_lo <= '0;
                a_hi <= '0;
                d_lo <= '0;
                d_hi <= '0;
            end else begin
                if (lane_wr && (widx == W_RD_ADR_LO || widx == W_WR_ADR_LO))
                    a_lo <= bus_wdata[b*8 +: 8];
                if (lane_wr && hi_adr)
                    a_hi <= bus_wdata[b*8 +: 8];
                if (capture) begin
                    d_lo <= wb_dat_i[b*8 +: 8];
                    d_hi <= wb_dat_i[BUS_W + b*8 +: 8];
                end else begin
                    if (lane_wr && widx == W_DAT_LO) d_lo <= bus_wdata[b*8 +: 8];
                    if (lane_wr && widx == W_DAT_HI) d_hi <= bus_wdata[b*8 +: 8];
                end
            end
        end

        assign adr_o[b*8 +: 8]         = a_lo;
        assign adr_o[BUS_W + b*8 +: 8] = a_hi;
        assign dat_o[b*8 +: 8]         = d_lo;
        assign dat_o[BUS_W + b*8 +: 8] = d_hi;
    end

    // Direction follows the address pair written; control takes the low lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q   <= 1'b0;
            sel_q  <= '0;
            pipe_q <= 1'b0;
        end else if (wr_open) begin
            case (widx)
                W_RD_ADR_LO, W_RD_ADR_HI: we_q <= 1'b0;
                W_WR_ADR_LO, W_WR_ADR_HI: we_q <= 1'b1;
                W_CTRL: if (bus_wren[0]) begin
                    sel_q  <= bus_wdata[SEL_W-1:0];
                    pipe_q <= bus_wdata[CTRL_PIPE_BIT];
                end
                default: ;
            endcase
        end
    end

    // Control word image as seen by a read.
    always_comb begin
        ctrl_word                = '0;
        ctrl_word[SEL_W-1:0]     = sel_q;
        ctrl_word[CTRL_PIPE_BIT] = pipe_q;
        ctrl_word[CTRL_PEND_BIT] = pending;
    end

    // Registered read port; write-only and reserved slots return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= '0;
            if (bus_rden) begin
                case (widx)
                    W_DAT_LO: bus_rdata <= dat_o[BUS_W-1:0];
                    W_DAT_HI: bus_rdata <= dat_o[WB_W-1:BUS_W];
                    W_CTRL:   bus_rdata <= ctrl_word;
                    default:  bus_rdata <= '0;
                endcase
            end
        end
    end

    assign sel_o  = sel_q;
    assign we_o   = we_q;
    assign pipe_o = pipe_q;

    AST_ADR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        pending && $past(pending) |-> $stable(adr_o) && $stable(we_q));  // R10
    AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        pending && wb_ack && !we_q |=> dat_o == $past(wb_dat_i));        // R9
    AST_WRITE_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        pending && wb_ack && we_q |=> $stable(dat_o));                   // R9
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rden |=> bus_rdata == '0);                                  // R11

endmodule

// File: rtl/wbbr_top.sv
// Module: register-window Wishbone master bridge, top level.
// Joins the register window to the cycle sequencer. The open-cycle flag is
// the pending status seen by software. Assumes a 16-bit host bus and a
// 32-bit Wishbone side.
module wbbr_top #(
    parameter int BUS_W  = 16,
    parameter int WB_W   = 32,
    parameter int WIDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDX_W-1:0]    bus_word,
    input  logic                 bus_rden,
    input  logic [BUS_W/8-1:0]   bus_wren,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic [WB_W-1:0]      wb_adr_o,
    output logic [WB_W-1:0]      wb_dat_o,
    input  logic [WB_W-1:0]      wb_dat_i,
    output logic [WB_W/8-1:0]    wb_sel_o,
    output logic                 wb_we_o,
    output logic                 wb_cyc_o,
    output logic                 wb_stb_o,
    input  logic                 wb_ack_i
);

    logic start;
    logic pipe;

    wbbr_regfile #(.BUS_W(BUS_W), .WB_W(WB_W), .WIDX_W(WIDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_word  (bus_word),
        .bus_rden  (bus_rden),
        .bus_wren  (bus_wren),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pending   (wb_cyc_o),
        .wb_ack    (wb_ack_i),
        .wb_dat_i  (wb_dat_i),
        .adr_o     (wb_adr_o),
        .dat_o     (wb_dat_o),
        .sel_o     (wb_sel_o),
        .we_o      (wb_we_o),
        .pipe_o    (pipe),
        .start     (start)
    );

    wbbr_cycle u_cycle (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .pipe  (pipe),
        .ack   (wb_ack_i),
        .cyc   (wb_cyc_o),
        .stb   (wb_stb_o)
    );

endmodule

// File: tb/wbbr_top_tb.sv
module wbbr_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_word = '0;
    logic        bus_rden = 1'b0;
    logic [1:0]  bus_wren = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] wb_adr_o, wb_dat_o;
    logic [31:0] wb_dat_i = '0;
    logic [3:0]  wb_sel_o;
    logic        wb_we_o, wb_cyc_o, wb_stb_o;
    logic        wb_ack_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_adr, exp_dat;
    logic        exp_we;
    logic [4:0]  exp_ctl;

    always #4 clk = ~clk;   // 125 MHz

    wbbr_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_rden(bus_rden),
        .bus_wren(bus_wren), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
        .wb_sel_o(wb_sel_o), .wb_we_o(wb_we_o), .wb_cyc_o(wb_cyc_o),
        .wb_stb_o(wb_stb_o), .wb_ack_i(wb_ack_i)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [1:0] s);
        merge = {s[1] ? d[15:8] : old[15:8], s[0] ? d[7:0] : old[7:0]};
    endfunction

    // All tasks start and end on a falling edge.
    task automatic wr(input logic [2:0] w, input logic [15:0] d, input logic [1:0] s);
        bus_word = w; bus_wdata = d; bus_wren = s;
        @(negedge clk);
        bus_wren = '0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [15:0] v);
        bus_word = w; bus_rden = 1'b1;
        @(negedge clk);
        bus_rden = 1'b0;
        v = bus_rdata;
    endtask

    task automatic ack_pulse(input logic [31:0] d);
        wb_ack_i = 1'b1; wb_dat_i = d;
        @(negedge clk);
        wb_ack_i = 1'b0;
    endtask

    // One transfer: direction, style, wait states before ACK.
    task automatic xfer(input bit is_wr, input bit pipe, input int waits,
                        input logic [15:0] lo, input logic [15:0] hi, input logic [31:0] ackd);
        exp_ctl = {pipe, 4'(waits * 5 + 1)};
        wr(3'd7, {11'd0, exp_ctl}, 2'b11);
        wr(is_wr ? 3'd2 : 3'd0, lo, 2'b11);
        wr(is_wr ? 3'd3 : 3'd1, hi, 2'b11);
        exp_adr = {hi, lo}; exp_we = is_wr;
        chk({31'd0, wb_cyc_o & wb_stb_o}, 32'd1, "R3 cycle opens");
        chk({31'd0, wb_we_o}, {31'd0, exp_we}, "R3 direction");
        chk(wb_adr_o, exp_adr, "R3 address");
        chk({28'd0, wb_sel_o}, {28'd0, exp_ctl[3:0]}, "R5 selects on bus");
        for (int c = 0; c < waits; c++) begin
            @(negedge clk);
            chk({31'd0, wb_cyc_o}, 32'd1, "R6 cyc held");
            chk({31'd0, wb_stb_o}, {31'd0, !pipe}, pipe ? "R7 single strobe" : "R6 strobe held");
        end
        ack_pulse(ackd);
        if (!is_wr) exp_dat = ackd;
        chk({30'd0, wb_cyc_o, wb_stb_o}, 32'd0, "R8 closed on ack");
        chk(wb_dat_o, exp_dat, "R9 data after ack");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk({29'd0, wb_cyc_o, wb_stb_o, wb_we_o}, 32'd0, "R1 bus idle");
        chk({28'd0, wb_sel_o}, 32'd0, "R1 selects");
        chk(wb_adr_o | wb_dat_o, 32'd0, "R1 address/data");
        rd(3'd7, v); chk({16'd0, v}, 32'd0, "R1 control");
        exp_adr = '0; exp_dat = '0; exp_we = 1'b0;

        // R2/R4 sweep over lanes of the non-triggering halves
        for (int i = 0; i < 4; i++) begin
            for (int s = 1; s < 4; s++) begin
                logic [2:0]  w;
                logic [15:0] d;
                w = (i == 0) ? 3'd0 : (i == 1) ? 3'd2 : (i == 2) ? 3'd4 : 3'd5;
                d = 16'hA5C3 ^ 16'(i * 16'h1111) ^ 16'(s * 16'h0F0F);
                wr(w, d, 2'(s));
                case (i)
                    0: begin exp_adr[15:0] = merge(exp_adr[15:0], d, 2'(s)); exp_we = 1'b0; end
                    1: begin exp_adr[15:0] = merge(exp_adr[15:0], d, 2'(s)); exp_we = 1'b1; end
                    2: exp_dat[15:0]  = merge(exp_dat[15:0], d, 2'(s));
                    default: exp_dat[31:16] = merge(exp_dat[31:16], d, 2'(s));
                endcase
                chk(wb_adr_o, exp_adr, "R2 address lanes");
                chk(wb_dat_o, exp_dat, "R2 data lanes");
                chk({31'd0, wb_we_o}, {31'd0, exp_we}, "R4 direction by pair");
            end
        end
        rd(3'd4, v); chk({16'd0, v}, {16'd0, exp_dat[15:0]}, "R2 data low readback");
        rd(3'd5, v); chk({16'd0, v}, {16'd0, exp_dat[31:16]}, "R2 data high readback");

        // R5 control sweep, high bits including bit 15 ignored on write
        for (int c = 0; c < 32; c++) begin
            wr(3'd7, 16'hFFE0 | 16'(c), 2'b11);
            chk({28'd0, wb_sel_o}, 32'(c & 15), "R5 selects");
            rd(3'd7, v); chk({16'd0, v}, 32'(c), "R5 control readback");
        end
        wr(3'd7, 16'h0000, 2'b10);
        rd(3'd7, v); chk({16'd0, v}, 32'd31, "R5 high-lane write ignored");

        // R11 write-only and reserved slots, idle read data
        for (int k = 0; k < 5; k++) begin
            rd((k == 4) ? 3'd6 : 3'(k == 0 ? 0 : k == 1 ? 1 : k == 2 ? 2 : 3), v);
            chk({16'd0, v}, 32'd0, "R11 write-only slot reads zero");
        end
        @(negedge clk);
        chk({16'd0, bus_rdata}, 32'd0, "R11 idle read data");

        // R3/R6/R7/R8/R9 sweep: direction x style x wait states
        for (int wdir = 0; wdir < 2; wdir++)
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < 4; k++)
                    xfer(wdir[0], p[0], k, 16'(16'h1000 + k * 4 + p * 16),
                         16'(16'hC000 + wdir * 256), 32'(32'h5A000000 + k * 32'h10101 + p + wdir * 2));

        // R8 pending bit readable during a classic read, clear after
        wr(3'd7, 16'h0003, 2'b11);
        wr(3'd1, 16'h7777, 2'b11);
        rd(3'd7, v); chk({16'd0, v}, 32'h8003, "R8 pending set");
        chk({31'd0, wb_stb_o}, 32'd1, "R6 strobe during poll");
        ack_pulse(32'hCAFE0001); exp_dat = 32'hCAFE0001;
        rd(3'd7, v); chk({16'd0, v}, 32'h0003, "R8 pending cleared");
        rd(3'd4, v); chk({16'd0, v}, 32'h0001, "R9 captured low half");
        rd(3'd5, v); chk({16'd0, v}, 32'hCAFE, "R9 captured high half");

        // R10 writes and triggers during an open pipelined write cycle
        wr(3'd7, 16'h001F, 2'b11);
        wr(3'd3, 16'h2222, 2'b11);
        exp_adr = wb_adr_o;
        wr(3'd4, 16'hBEEF, 2'b11);
        wr(3'd1, 16'h3333, 2'b11);
        wr(3'd7, 16'h0000, 2'b11);
        chk(wb_dat_o, exp_dat, "R10 data write ignored");
        chk(wb_adr_o, exp_adr, "R10 address kept");
        chk({31'd0, wb_we_o}, 32'd1, "R10 trigger ignored");
        chk({28'd0, wb_sel_o}, 32'hF, "R10 control kept");
        ack_pulse(32'h01234567);
        chk(wb_dat_o, exp_dat, "R9 write ack keeps data");

        // Collision: read ACK and data write in the same clock
        wr(3'd1, 16'h4444, 2'b11);
        bus_word = 3'd4; bus_wdata = 16'h1357; bus_wren = 2'b11;
        wb_ack_i = 1'b1; wb_dat_i = 32'h89ABCDEF;
        @(negedge clk);
        bus_wren = '0; wb_ack_i = 1'b0;
        chk(wb_dat_o, 32'h89ABCDEF, "R10 capture wins over write");
        chk({31'd0, wb_cyc_o}, 32'd0, "R8 closed in collision");
        exp_dat = 32'h89ABCDEF;

        // R12 ACK while idle
        ack_pulse(32'hDEADBEEF);
        @(negedge clk);
        chk(wb_dat_o, exp_dat, "R12 idle ack ignored");
        chk({30'd0, wb_cyc_o, wb_stb_o}, 32'd0, "R12 bus stays idle");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule